// File: doc/BRIEF.md
# Banked Asynchronous SRAM Controller

This block gives a clocked host byte access to an asynchronous 2M x 8 static memory built from sixteen 128K x 8 banks. The host raises a request with a write flag, a 21-bit byte address and a data byte. While the controller is idle and ready, it accepts the request, stores those values and runs one memory cycle. Each memory limit in nanoseconds becomes a count of clock cycles, rounded up, with a floor of one cycle.

A bank is enabled only when two selects are active together: its own active-low select, and the active-high select shared by its pair of banks. With no access in progress, every bank select is high and every pair select is low, so the memory is powered down and does not drive the bus. A retention request forces this deselected state with output enable high. After the request is released, the controller waits one read cycle time before it accepts another access.

With the default 4 ns clock, the limits become these counts: a 9-cycle write pulse, a 10-cycle read access, 5 cycles of bus float after a read, and 10 cycles of recovery after retention.

Top module: `sram_bank_ctrl`

## Requirements
- R1: After reset and whenever ready is high, all 16 bank selects are high, all 8 pair selects are low, write enable and output enable are high, and the data drivers are off.
- R2: During an access exactly one bank select is low, at index b = hostAddr[20:17]. Exactly one pair select is high, at index b/2. memAddr equals hostAddr[16:0].
- R3: A write asserts the selects, then drives write enable low for at least ceil(35 ns / clock) cycles (9 at default) with address and data stable. It then keeps the address and selects for at least one more cycle after write enable rises. A write keeps ready low for exactly 11 cycles at default.
- R4: Output enable stays high for as long as write enable is low, and write enable stays high for the whole of a read.
- R5: A read holds output enable low with the selects for at least ceil(40 ns / clock) cycles before it captures memDataIn. hostRdData keeps the captured byte until the next read completes, including across writes.
- R6: After a read the controller deselects the memory and keeps its drivers off for at least ceil(20 ns / clock) cycles (5 at default). Its drivers are never on while the memory drives or may still drive the bus. A read keeps ready low for exactly 17 cycles at default.
- R7: Ready is high only when idle. The address, data and write flag are taken on the clock edge that accepts the request, and later changes to those inputs have no effect on the access.
- R8: While retReq is high and the controller has left idle, the memory stays deselected with output enable high. If retReq and hostReq are both high in idle, retention wins.
- R9: After retReq falls, ready stays low for exactly ceil(40 ns / clock) cycles (10 at default). A request held through retention is then served.
- R10: Back-to-back accesses to any of the 16 banks, including the highest address 0x1FFFFF, store and return the correct bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostReq | input | 1 | Access request, taken when hostReady is high |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 21 | Byte address |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Byte captured by the last read |
| hostReady | output | 1 | Controller idle and accepting requests |
| retReq | input | 1 | Retention / standby request |
| memAddr | output | 17 | Address shared by all banks |
| memCsN | output | 16 | Active-low bank selects |
| memPairSel | output | 8 | Active-high pair selects |
| memWeN | output | 1 | Active-low write enable |
| memOeN | output | 1 | Active-low output enable |
| memDataIn | input | 8 | Data bus from memory |
| memDataOut | output | 8 | Data bus to memory |
| memDataOe | output | 1 | Drive enable for memDataOut |

## Verification
The memory outputs change only after the clock edge that moves the state machine. The bench therefore samples them, and updates its memory model, on the falling edge that follows. Busy time is measured from the edge that accepts a request, by counting falling edges with ready low: 11 for a write, 17 for a read and 10 for recovery.

The memory model returns the inverted byte until output enable has been low for 10 sampled cycles, so a capture that comes too early shows up as wrong read data. A float counter, reloaded with 5 whenever the memory drives, detects the controller driving the bus too soon.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [3:0] {
    IDLE, SETUP, WR_PULSE, WR_HOLD, RD_WAIT, RD_CAPTURE, TURNAROUND, RETAIN, RECOVER
  } sbc_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;    // take host request
    logic selOn;    // assert decoded bank and pair select
    logic weLow;    // write enable active
    logic oeLow;    // output enable active
    logic drive;    // controller drives the data bus
    logic capture;  // sample read data
  } sbc_strobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int T_WC   = 40,
  parameter int T_WP   = 35,
  parameter int T_DS   = 35,
  parameter int T_AH   = 3,
  parameter int T_RC   = 40,
  parameter int T_AA   = 40,
  parameter int T_OE   = 15,
  parameter int T_OHZ  = 10,
  parameter int T_DHZ  = 20,
  parameter int T_REC  = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        retReq,
  input  logic        wrLatched,
  output logic        ready,
  output sbc_strobe_t strb
);

  localparam int WP_CYC  = maxInt(nsToCycles(T_WP, CLK_NS), nsToCycles(T_DS, CLK_NS));
  localparam int WC_CYC  = nsToCycles(T_WC, CLK_NS);
  localparam int AH_CYC  = nsToCycles(T_AH, CLK_NS);
  localparam int WH_CYC  = maxInt(AH_CYC, WC_CYC - 1 - WP_CYC);
  localparam int RD_CYC  = maxInt(maxInt(nsToCycles(T_AA, CLK_NS), nsToCycles(T_OE, CLK_NS)),
                                  nsToCycles(T_RC, CLK_NS) - 2);
  localparam int TA_CYC  = maxInt(nsToCycles(T_OHZ, CLK_NS), nsToCycles(T_DHZ, CLK_NS));
  localparam int REC_CYC = nsToCycles(T_REC, CLK_NS);
  localparam int MAX_CYC = maxInt(maxInt(WP_CYC, WH_CYC), maxInt(maxInt(RD_CYC, TA_CYC), REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  sbc_state_e state, stateNxt;
  logic [CNT_W-1:0] cnt, loadVal;
  logic load, done;

  assign done = (cnt == '0);

  always_comb begin
    stateNxt = state;
    load     = 1'b0;
    loadVal  = '0;
    unique case (state)
      IDLE: begin
        if (retReq)       stateNxt = RETAIN;
        else if (hostReq) stateNxt = SETUP;
      end
      SETUP: begin
        load = 1'b1;
        if (wrLatched) begin
          stateNxt = WR_PULSE;
          loadVal  = CNT_W'(WP_CYC - 1);
        end else begin
          stateNxt = RD_WAIT;
          loadVal  = CNT_W'(RD_CYC - 1);
        end
      end
      WR_PULSE: if (done) begin
        stateNxt = WR_HOLD;
        load     = 1'b1;
        loadVal  = CNT_W'(WH_CYC - 1);
      end
      WR_HOLD:    if (done) stateNxt = IDLE;
      RD_WAIT:    if (done) stateNxt = RD_CAPTURE;
      RD_CAPTURE: begin
        stateNxt = TURNAROUND;
        load     = 1'b1;
        loadVal  = CNT_W'(TA_CYC - 1);
      end
      TURNAROUND: if (done) stateNxt = IDLE;
      RETAIN: if (!retReq) begin
        stateNxt = RECOVER;
        load     = 1'b1;
        loadVal  = CNT_W'(REC_CYC - 1);
      end
      RECOVER:    if (done) stateNxt = IDLE;
      default:    stateNxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      if (load)      cnt <= loadVal;
      else if (!done) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strb  = '0;
    ready = (state == IDLE);
    unique case (state)
      IDLE:       strb.latch = hostReq && !retReq;
      SETUP:      begin strb.selOn = 1'b1; strb.drive = wrLatched; end
      WR_PULSE:   begin strb.selOn = 1'b1; strb.weLow = 1'b1; strb.drive = 1'b1; end
      WR_HOLD:    begin strb.selOn = 1'b1; strb.drive = 1'b1; end
      RD_WAIT:    begin strb.selOn = 1'b1; strb.oeLow = 1'b1; end
      RD_CAPTURE: begin strb.selOn = 1'b1; strb.oeLow = 1'b1; strb.capture = 1'b1; end
      default:    strb = '0;
    endcase
  end

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int BANK_AW   = 17,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbc_strobe_t          strb,
  input  logic                 hostWrite,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData,
  output logic                 wrLatched,
  output logic [BANK_AW-1:0]   memAddr,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic [NUM_BANKS/2-1:0] memPairSel,
  output logic                 memWeN,
  output logic                 memOeN,
  input  logic [DATA_W-1:0]    memDataIn,
  output logic [DATA_W-1:0]    memDataOut,
  output logic                 memDataOe
);

  localparam int BANK_W    = ADDR_W - BANK_AW;
  localparam int NUM_PAIRS = NUM_BANKS / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdQ;
  logic              wrQ;
  logic [BANK_W-1:0] bankIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      wrQ   <= 1'b0;
      rdQ   <= '0;
    end else begin
      if (strb.latch) begin
        addrQ <= hostAddr;
        dataQ <= hostWrData;
        wrQ   <= hostWrite;
      end
      if (strb.capture) rdQ <= memDataIn;
    end
  end

  assign bankIdx = addrQ[ADDR_W-1:BANK_AW];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign memCsN[b] = !(strb.selOn && (bankIdx == BANK_W'(b)));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign memPairSel[p] = strb.selOn && (bankIdx[BANK_W-1:1] == (BANK_W-1)'(p));
  end

  assign memAddr    = addrQ[BANK_AW-1:0];
  assign memWeN     = !strb.weLow;
  assign memOeN     = !strb.oeLow;
  assign memDataOut = dataQ;
  assign memDataOe  = strb.drive;
  assign hostRdData = rdQ;
  assign wrLatched  = wrQ;

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int BANK_AW   = 17,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 16,
  parameter int CLK_NS    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostReq,
  input  logic                   hostWrite,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic [DATA_W-1:0]      hostWrData,
  output logic [DATA_W-1:0]      hostRdData,
  output logic                   hostReady,
  input  logic                   retReq,
  output logic [BANK_AW-1:0]     memAddr,
  output logic [NUM_BANKS-1:0]   memCsN,
  output logic [NUM_BANKS/2-1:0] memPairSel,
  output logic                   memWeN,
  output logic                   memOeN,
  input  logic [DATA_W-1:0]      memDataIn,
  output logic [DATA_W-1:0]      memDataOut,
  output logic                   memDataOe
);

  sbc_strobe_t strb;
  logic        wrLatched;

  sbc_ctrl #(.CLK_NS(CLK_NS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .retReq    (retReq),
    .wrLatched (wrLatched),
    .ready     (hostReady),
    .strb      (strb)
  );

  sbc_datapath #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWrite  (hostWrite),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .wrLatched  (wrLatched),
    .memAddr    (memAddr),
    .memCsN     (memCsN),
    .memPairSel (memPairSel),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .memDataIn  (memDataIn),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe)
  );

endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
  parameter int BANK_AW   = 17,
  parameter int NUM_BANKS = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   hostReady,
  input logic                   retReq,
  input logic [BANK_AW-1:0]     memAddr,
  input logic [NUM_BANKS-1:0]   memCsN,
  input logic [NUM_BANKS/2-1:0] memPairSel,
  input logic                   memWeN,
  input logic                   memOeN,
  input logic                   memDataOe
);

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> ((&memCsN) && (memPairSel == '0) && memOeN && memWeN && !memDataOe));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~memCsN));

  // R2
  one_pair_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(memPairSel));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pairchk
    // R2
    pair_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      !memCsN[b] |-> memPairSel[b/2]);
  end

  // R3
  we_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !(&memCsN));

  // R3
  we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R3
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!(&memCsN) && $stable(memAddr)));

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R6
  drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memOeN);

  // R6
  read_end_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (!memDataOe && (&memCsN)));

  // R8
  retain_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && retReq) |=> (!hostReady && (&memCsN) && memOeN));

endmodule

bind sram_bank_ctrl sbc_chk #(.BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostReady  (hostReady),
  .retReq     (retReq),
  .memAddr    (memAddr),
  .memCsN     (memCsN),
  .memPairSel (memPairSel),
  .memWeN     (memWeN),
  .memOeN     (memOeN),
  .memDataOe  (memDataOe)
);

// File: tb/tb_sram_bank_ctrl.sv
module tb_sram_bank_ctrl;

  localparam int WR_BUSY   = 11;
  localparam int RD_BUSY   = 17;
  localparam int REC_BUSY  = 10;
  localparam int WP_MIN    = 9;
  localparam int RD_VALID  = 10;
  localparam int FLOAT_CYC = 5;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0, retReq = 1'b0;
  logic [20:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0, memIn = '0;
  logic [7:0]  hostRdData, memDataOut;
  logic        hostReady, memWeN, memOeN, memDataOe;
  logic [16:0] memAddr;
  logic [15:0] memCsN;
  logic [7:0]  memPairSel;

  int total = 0, bad = 0;
  bit monOn = 1'b0, finished = 1'b0;
  logic [20:0] curAddr = '0;
  logic [7:0]  curData = '0;
  logic [7:0]  memArr [int];
  logic [7:0]  shadow [int];
  int weRun = 0, floatCnt = 0, validCnt = 0;

  always #2 clk = ~clk;

  sram_bank_ctrl dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostReady(hostReady), .retReq(retReq), .memAddr(memAddr), .memCsN(memCsN),
    .memPairSel(memPairSel), .memWeN(memWeN), .memOeN(memOeN), .memDataIn(memIn),
    .memDataOut(memDataOut), .memDataOe(memDataOe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and protocol monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (monOn) begin
      int nLow, idx;
      bit drv;
      logic [20:0] seen;
      logic [7:0] rdByte;
      nLow = $countones(~memCsN);
      idx = 0;
      for (int b = 0; b < 16; b++) if (!memCsN[b]) idx = b;
      seen = {4'(idx), memAddr};
      check(nLow <= 1, "R2 single bank select", nLow, 1);
      if (nLow == 1) begin
        check(memPairSel == (8'b1 << (idx / 2)), "R2 pair select", memPairSel, 8'b1 << (idx / 2));
        check(seen == curAddr, "R2 bank and row address", seen, curAddr);
      end else begin
        check(memPairSel == 8'h00, "R1 pair selects low when deselected", memPairSel, 0);
      end
      if (!memWeN) begin
        check(memOeN && nLow == 1 && memDataOe && memDataOut == curData,
              "R4 write overlap with output enable high", {memOeN, memDataOe, memDataOut}, {2'b11, curData});
        weRun++;
      end else if (weRun > 0) begin
        check(weRun >= WP_MIN, "R3 write pulse width", weRun, WP_MIN);
        check(nLow == 1 && seen == curAddr, "R3 address hold after write", seen, curAddr);
        memArr[int'(curAddr)] = memDataOut;
        weRun = 0;
      end
      drv = (nLow == 1) && memPairSel[idx / 2] && !memOeN && memWeN;
      check(!(memDataOe && (drv || floatCnt > 0)), "R6 bus contention", floatCnt, 0);
      if (drv) floatCnt = FLOAT_CYC;
      else if (floatCnt > 0) floatCnt--;
      if (drv && seen == curAddr) validCnt++;
      else validCnt = 0;
      rdByte = memArr.exists(int'(curAddr)) ? memArr[int'(curAddr)] : 8'h00;
      memIn = !drv ? 8'h00 : ((validCnt >= RD_VALID) ? rdByte : ~rdByte);
      if (retReq && !hostReady)
        check((&memCsN) && memPairSel == 0 && memOeN && !memDataOe,
              "R8 deselected during retention", {memCsN, memPairSel}, 24'hFFFF00);
    end
  end

  task automatic access(input bit wr, input logic [20:0] a, input logic [7:0] d, output int busy);
    @(negedge clk);
    curAddr = a; curData = d;
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWrData = d;
    if (wr) shadow[int'(a)] = d;
    @(negedge clk);
    hostReq = 1'b0; hostWrite = !wr; hostAddr = ~a; hostWrData = ~d;  // R7 changes after acceptance
    check(hostReady == 1'b0, "R7 ready low after acceptance", hostReady, 0);
    busy = 1;
    forever begin
      @(negedge clk);
      if (hostReady) break;
      busy++;
    end
  endtask

  task automatic doWrite(input logic [20:0] a, input logic [7:0] d);
    int busy;
    access(1'b1, a, d, busy);
    check(busy == WR_BUSY, "R3 write busy cycles", busy, WR_BUSY);
  endtask

  task automatic doRead(input logic [20:0] a);
    int busy;
    logic [7:0] exp;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    access(1'b0, a, 8'h00, busy);
    check(busy == RD_BUSY, "R6 read busy cycles", busy, RD_BUSY);
    check(hostRdData == exp, "R5 read data", hostRdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hostReady && (&memCsN) && memPairSel == 0 && memWeN && memOeN && !memDataOe,
          "R1 reset state", {hostReady, memCsN, memPairSel}, {1'b1, 16'hFFFF, 8'h00});
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    check(hostReady && (&memCsN), "R1 idle after reset", {hostReady, memCsN}, 17'h1FFFF);

    doWrite(21'h000005, 8'hA5);
    doRead(21'h000005);

    // R10 every bank, back to back
    for (int b = 0; b < 16; b++) doWrite({4'(b), 17'(b * 4099 + 7)}, 8'(8'h30 + b * 11));
    for (int b = 15; b >= 0; b--) doRead({4'(b), 17'(b * 4099 + 7)});

    // R10 highest address and bank 15
    doWrite(21'h1FFFFF, 8'h3C);
    doRead(21'h1FFFFF);

    // R5 read data held across a write
    doRead(21'h000005);
    doWrite(21'h0AAAAA, 8'h77);
    check(hostRdData == 8'hA5, "R5 read data held across write", hostRdData, 8'hA5);
    doRead(21'h0AAAAA);

    // R8 retention with a request pending at the same time
    begin
      int cnt;
      @(negedge clk);
      curAddr = 21'h155555; curData = 8'hC3;
      retReq = 1'b1; hostReq = 1'b1; hostWrite = 1'b1;
      hostAddr = 21'h155555; hostWrData = 8'hC3;
      shadow[int'(21'h155555)] = 8'hC3;
      @(negedge clk);
      check(!hostReady && (&memCsN) && memOeN, "R8 retention wins over request",
            {hostReady, memCsN}, 17'h0FFFF);
      repeat (20) @(negedge clk);
      retReq = 1'b0;
      cnt = 0;
      forever begin
        @(negedge clk);
        if (hostReady) break;
        check((&memCsN) && memOeN, "R9 deselected during recovery", memCsN, 16'hFFFF);
        cnt++;
      end
      check(cnt == REC_BUSY, "R9 recovery cycles", cnt, REC_BUSY);
      @(negedge clk);
      hostReq = 1'b0;
      check(!hostReady, "R9 held request served", hostReady, 0);
      while (!hostReady) @(negedge clk);
      doRead(21'h155555);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule